// File: doc/BRIEF.md
# Stream Array Receiver with Length Check

This block takes a stream of fixed-width words, framed into packets by an end-of-packet marker (TLAST), and rebuilds wider elements from them. Each element is made of a fixed number of consecutive words. Each rebuilt element leaves on a valid/ready output together with a flag that marks the final element of an array. A one-cycle completion pulse reports the number of whole elements received. Sticky error flags report framing faults until a clear input is pulsed.

The block has two modes, selected by `mode_pull` and sampled each time the block is idle between packets.

- **Pull mode.** The consumer first hands over an exact element count through a small command handshake. The block then expects exactly that many elements' worth of words. If the packet ends too soon, it reports an early end. If the count is reached with no end marker, it reports a missing end and throws away the rest of that packet.
- **Push mode.** No count is given. The block infers the element count from where the packet ends, and flags a packet whose length does not fill a whole number of elements.

Top module: `stream_array_rx`

## Requirements
- R1: In pull mode the block waits in idle with `cmd_ready` high and `s_tready` low; it accepts no word until a command is taken, and the command's `cmd_count` sets the expected length to `cmd_count * WPE` words.
- R2: In pull mode, a packet of exactly `cmd_count * WPE` words whose last word carries TLAST yields `cmd_count` elements. Only the final one has `m_last` high. `done` pulses once with `elem_count = cmd_count`, and no error flag is raised.
- R3: In pull mode, if TLAST comes before the expected word count, `err_early` is set. Elements already completed are delivered, none with `m_last` high, and any partial element is dropped. `done` pulses with the number of whole elements.
- R4: In pull mode, if the expected word count is reached on a word without TLAST, the final element leaves with `m_last` high. `err_missing` is set and `done` pulses with `elem_count = cmd_count`. The block then accepts and discards words up to and including the next TLAST, producing no output, and then returns to idle.
- R5: In push mode, the number of elements equals the packet's word count divided by `WPE`. `m_last` is high on the element whose final word carries TLAST, and `done` pulses with that count.
- R6: In push mode, a TLAST that does not fall on the final word of an element sets `err_partial`. The partial element is dropped, and `done` reports the whole elements only.
- R7: Word k (counting from 0) of an element appears in bits `[k*WORD_W +: WORD_W]` of `m_elem`.
- R8: While `m_valid` is high and `m_ready` is low, `m_elem` and `m_last` hold steady. During reception `s_tready` stays low in that state, so no word is lost.
- R9: The error flags stay set until `clr_err` is pulsed. If an error is detected in the same cycle as the clear, the new error remains set.
- R10: A pull-mode command with `cmd_count = 0` pulses `done` with `elem_count = 0`, consumes no word and produces no element.
- R11: After reset, `m_valid`, `done` and all error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pull | input | 1 | 1 = count given per packet, 0 = count inferred; sampled while idle |
| cmd_valid | input | 1 | Element count command valid (pull mode) |
| cmd_count | input | CNT_W | Requested element count |
| cmd_ready | output | 1 | Block is idle in pull mode and takes a command |
| s_tdata | input | WORD_W | Incoming stream word |
| s_tvalid | input | 1 | Incoming word valid |
| s_tlast | input | 1 | Incoming word ends the packet |
| s_tready | output | 1 | Block accepts the incoming word |
| m_elem | output | WORD_W*WPE | Rebuilt element |
| m_last | output | 1 | Final element of the array |
| m_valid | output | 1 | Element output valid |
| m_ready | input | 1 | Consumer takes the element |
| clr_err | input | 1 | Clears the sticky error flags |
| done | output | 1 | One-cycle pulse at the end of each array |
| elem_count | output | CNT_W | Whole elements received in the last array |
| err_early | output | 1 | Sticky: packet ended before the requested length |
| err_missing | output | 1 | Sticky: requested length reached with no TLAST |
| err_partial | output | 1 | Sticky: push-mode packet ended inside an element |

## Verification
The bench builds the block with `WORD_W = 16`, `WPE = 3` and `CNT_W = 4`. Three words per element means a packet can end on the first or on the second word of an element, which gives an early end, a partial element and a missing end at distinct word positions. Distinct 16-bit word values make any misplaced word inside a 48-bit element visible. A random stall pattern on `m_ready` tests that the input is held off while the single output register is full.

// File: rtl/stream_array_rx_pkg.sv
package stream_array_rx_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_RECV  = 2'd1,
    S_DRAIN = 2'd2
  } rx_state_t;
endpackage

// File: rtl/stream_array_rx_pack.sv
// Gathers WPE words into one element, first word in the low bits.
module stream_array_rx_pack #(
  parameter int WORD_W = 32,
  parameter int WPE    = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  wr,
  input  logic [WORD_W-1:0]     wdata,
  output logic                  at_last,
  output logic [WORD_W*WPE-1:0] elem
);
  generate
    if (WPE == 1) begin : g_single
      assign at_last = 1'b1;
      assign elem    = wdata;
    end else begin : g_multi
      localparam int IW = $clog2(WPE);
      logic [IW-1:0]              idx;
      logic [(WPE-1)*WORD_W-1:0]  hold;

      always_ff @(posedge clk) begin
        if (rst || flush) begin
          idx <= '0;
        end else if (wr) begin
          if (idx == IW'(WPE - 1)) idx <= '0;
          else                     idx <= idx + 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (wr && idx != IW'(WPE - 1))
          hold[idx*WORD_W +: WORD_W] <= wdata;
      end

      assign at_last = (idx == IW'(WPE - 1));
      assign elem    = {wdata, hold};
    end
  endgenerate
endmodule

// File: rtl/stream_array_rx_oreg.sv
// Single-entry registered output stage.
module stream_array_rx_oreg #(
  parameter int EW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [EW-1:0] din,
  input  logic          lin,
  input  logic          ready,
  output logic          valid,
  output logic [EW-1:0] dout,
  output logic          lout
);
  always_ff @(posedge clk) begin
    if (rst)        valid <= 1'b0;
    else if (load)  valid <= 1'b1;
    else if (ready) valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      dout <= din;
      lout <= lin;
    end
  end
endmodule

// File: rtl/stream_array_rx.sv
module stream_array_rx
  import stream_array_rx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WPE    = 2,
  parameter int CNT_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mode_pull,
  input  logic                  cmd_valid,
  input  logic [CNT_W-1:0]      cmd_count,
  output logic                  cmd_ready,
  input  logic [WORD_W-1:0]     s_tdata,
  input  logic                  s_tvalid,
  input  logic                  s_tlast,
  output logic                  s_tready,
  output logic [WORD_W*WPE-1:0] m_elem,
  output logic                  m_last,
  output logic                  m_valid,
  input  logic                  m_ready,
  input  logic                  clr_err,
  output logic                  done,
  output logic [CNT_W-1:0]      elem_count,
  output logic                  err_early,
  output logic                  err_missing,
  output logic                  err_partial
);
  localparam int EW  = WORD_W * WPE;
  localparam int WCW = CNT_W + $clog2(WPE) + 1;

  rx_state_t        state;
  logic             mode_q;
  logic [WCW-1:0]   exp_w, wcnt, wnext;
  logic [CNT_W-1:0] ecnt;
  logic             out_free, acc, at_last, elem_done, pull_hit, flush;
  logic [EW-1:0]    elem_w;

  assign out_free  = !m_valid || m_ready;
  assign s_tready  = (state == S_RECV && out_free) || state == S_DRAIN;
  assign cmd_ready = (state == S_IDLE) && mode_pull;
  assign acc       = (state == S_RECV) && s_tvalid && out_free;
  assign elem_done = acc && at_last;
  assign wnext     = wcnt + 1'b1;
  assign pull_hit  = mode_q && (wnext == exp_w);
  assign flush     = acc && (s_tlast || pull_hit);

  stream_array_rx_pack #(.WORD_W(WORD_W), .WPE(WPE)) u_pack (
    .clk(clk), .rst(rst), .flush(flush), .wr(acc), .wdata(s_tdata),
    .at_last(at_last), .elem(elem_w)
  );

  stream_array_rx_oreg #(.EW(EW)) u_oreg (
    .clk(clk), .rst(rst), .load(elem_done), .din(elem_w),
    .lin(mode_q ? pull_hit : s_tlast), .ready(m_ready),
    .valid(m_valid), .dout(m_elem), .lout(m_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      mode_q      <= 1'b0;
      exp_w       <= '0;
      wcnt        <= '0;
      ecnt        <= '0;
      done        <= 1'b0;
      elem_count  <= '0;
      err_early   <= 1'b0;
      err_missing <= 1'b0;
      err_partial <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clr_err) begin
        err_early   <= 1'b0;
        err_missing <= 1'b0;
        err_partial <= 1'b0;
      end
      case (state)
        S_IDLE: begin
          wcnt <= '0;
          ecnt <= '0;
          if (!mode_pull) begin
            mode_q <= 1'b0;
            state  <= S_RECV;
          end else if (cmd_valid) begin
            mode_q <= 1'b1;
            if (cmd_count == '0) begin
              done       <= 1'b1;
              elem_count <= '0;
            end else begin
              exp_w <= WCW'(cmd_count) * WCW'(WPE);
              state <= S_RECV;
            end
          end
        end
        S_RECV: begin
          if (acc) begin
            if (s_tlast) begin
              done       <= 1'b1;
              elem_count <= ecnt + CNT_W'(elem_done);
              state      <= S_IDLE;
              if (mode_q && !pull_hit)   err_early   <= 1'b1;
              if (!mode_q && !elem_done) err_partial <= 1'b1;
            end else if (pull_hit) begin
              done        <= 1'b1;
              elem_count  <= ecnt + 1'b1;
              err_missing <= 1'b1;
              state       <= S_DRAIN;
            end else begin
              wcnt <= wnext;
              if (elem_done) ecnt <= ecnt + 1'b1;
            end
          end
        end
        S_DRAIN: begin
          if (s_tvalid && s_tlast) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stream_array_rx_chk.sv
module stream_array_rx_chk
  import stream_array_rx_pkg::*;
#(
  parameter int EW = 64
) (
  input logic          clk,
  input logic          rst,
  input rx_state_t     state,
  input logic          cmd_ready,
  input logic          s_tready,
  input logic [EW-1:0] m_elem,
  input logic          m_last,
  input logic          m_valid,
  input logic          m_ready,
  input logic          clr_err,
  input logic          done,
  input logic          err_early,
  input logic          err_missing,
  input logic          err_partial
);
  p_cmd_gate_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !s_tready);

  p_early_done_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(err_early) |-> done);

  p_missing_done_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(err_missing) |-> done);

  p_partial_done_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(err_partial) |-> done);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_elem) && $stable(m_last)));

  p_no_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_RECV && m_valid && !m_ready) |-> !s_tready);

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (err_early && !clr_err) |=> err_early);

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clr_err |=> (done || (!err_early && !err_missing && !err_partial)));
endmodule

bind stream_array_rx stream_array_rx_chk #(.EW(WORD_W * WPE)) u_chk (
  .clk(clk), .rst(rst), .state(state), .cmd_ready(cmd_ready),
  .s_tready(s_tready), .m_elem(m_elem), .m_last(m_last), .m_valid(m_valid),
  .m_ready(m_ready), .clr_err(clr_err), .done(done), .err_early(err_early),
  .err_missing(err_missing), .err_partial(err_partial)
);

// File: tb/stream_array_rx_bench.sv
`timescale 1ns/1ps
module stream_array_rx_bench;
  localparam int WW = 16;
  localparam int WP = 3;
  localparam int CW = 4;
  localparam int EW = WW * WP;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_pull = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [CW-1:0] cmd_count = '0;
  logic          cmd_ready;
  logic [WW-1:0] s_tdata = '0;
  logic          s_tvalid = 1'b0;
  logic          s_tlast = 1'b0;
  logic          s_tready;
  logic [EW-1:0] m_elem;
  logic          m_last, m_valid;
  logic          m_ready = 1'b1;
  logic          clr_err = 1'b0;
  logic          done;
  logic [CW-1:0] elem_count;
  logic          err_early, err_missing, err_partial;

  always #2 clk = ~clk;

  stream_array_rx #(.WORD_W(WW), .WPE(WP), .CNT_W(CW)) u_stream_array_rx (
    .clk(clk), .rst(rst), .mode_pull(mode_pull), .cmd_valid(cmd_valid),
    .cmd_count(cmd_count), .cmd_ready(cmd_ready), .s_tdata(s_tdata),
    .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
    .m_elem(m_elem), .m_last(m_last), .m_valid(m_valid), .m_ready(m_ready),
    .clr_err(clr_err), .done(done), .elem_count(elem_count),
    .err_early(err_early), .err_missing(err_missing), .err_partial(err_partial)
  );

  int tests = 0;
  int fails = 0;
  logic [EW:0] exp_q[$];
  int          cnt_q[$];
  bit          stall_en = 1'b0;
  int unsigned rnd = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // consumer stall pattern
  always @(negedge clk) begin
    rnd = rnd * 32'd1103515245 + 32'd12345;
    m_ready = stall_en ? rnd[16] : 1'b1;
  end

  // reference comparison of every output transfer and completion pulse
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected element", longint'(m_elem), 0);
        end else begin
          logic [EW:0] e;
          e = exp_q.pop_front();
          chk(m_elem == e[EW-1:0], "R7", "element data", longint'(m_elem), longint'(e[EW-1:0]));
          chk(m_last == e[EW], "R2", "last flag", longint'(m_last), longint'(e[EW]));
        end
      end
      if (done) begin
        if (cnt_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected done", longint'(elem_count), 0);
        end else begin
          int c;
          c = cnt_q.pop_front();
          chk(int'(elem_count) == c, "R5", "element count", longint'(elem_count), longint'(c));
        end
      end
    end
  end

  function automatic logic [WW-1:0] wv(input int base, input int i);
    return WW'(base + i * 7 + 1);
  endfunction

  task automatic expect_elems(input int base, input int nfull, input bit last_on_final);
    for (int j = 0; j < nfull; j++) begin
      logic [EW-1:0] d;
      for (int k = 0; k < WP; k++) d[k*WW +: WW] = wv(base, j*WP + k);
      exp_q.push_back({(last_on_final && j == nfull - 1), d});
    end
  endtask

  task automatic send_pkt(input int base, input int nwords, input int last_idx);
    for (int i = 0; i < nwords; i++) begin
      @(negedge clk);
      s_tvalid = 1'b1;
      s_tdata  = wv(base, i);
      s_tlast  = (i == last_idx);
      #1;
      while (!s_tready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  task automatic send_cmd(input int n);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_count = CW'(n);
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic settle(input string req);
    repeat (12) @(negedge clk);
    #1;
    chk(exp_q.size() == 0, req, "elements outstanding", exp_q.size(), 0);
    chk(cnt_q.size() == 0, req, "done pulses outstanding", cnt_q.size(), 0);
  endtask

  task automatic clear_flags();
    @(negedge clk);
    clr_err = 1'b1;
    @(negedge clk);
    clr_err = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R11 reset state
    chk(m_valid == 1'b0, "R11", "m_valid after reset", m_valid, 0);
    chk(done == 1'b0, "R11", "done after reset", done, 0);
    chk({err_early, err_missing, err_partial} == 3'b000, "R11", "flags after reset",
        {err_early, err_missing, err_partial}, 0);
    chk(cmd_ready == 1'b1, "R1", "cmd_ready idle pull", cmd_ready, 1);

    // R1 no word accepted before a command
    s_tvalid = 1'b1;
    s_tdata  = 16'hdead;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk(s_tready == 1'b0, "R1", "tready before command", s_tready, 0);
    end
    s_tvalid = 1'b0;

    // R2 exact pull packet
    expect_elems(16'h100, 2, 1'b1);
    cnt_q.push_back(2);
    send_cmd(2);
    send_pkt(16'h100, 6, 5);
    settle("R2");
    chk({err_early, err_missing, err_partial} == 3'b000, "R2", "no error", 
        {err_early, err_missing, err_partial}, 0);

    // R8 exact pull packet under output stalls
    stall_en = 1'b1;
    expect_elems(16'h200, 4, 1'b1);
    cnt_q.push_back(4);
    send_cmd(4);
    send_pkt(16'h200, 12, 11);
    settle("R8");
    stall_en = 1'b0;

    // R3 early TLAST on the second word of the second element
    expect_elems(16'h300, 1, 1'b0);
    cnt_q.push_back(1);
    send_cmd(2);
    send_pkt(16'h300, 5, 4);
    settle("R3");
    chk(err_early == 1'b1, "R3", "err_early set", err_early, 1);
    chk(err_missing == 1'b0, "R3", "err_missing clear", err_missing, 0);

    // R9 sticky until clear
    repeat (3) @(negedge clk);
    #1;
    chk(err_early == 1'b1, "R9", "err_early sticky", err_early, 1);
    clear_flags();
    chk(err_early == 1'b0, "R9", "err_early cleared", err_early, 0);

    // R4 missing TLAST, two extra words discarded
    expect_elems(16'h400, 1, 1'b1);
    cnt_q.push_back(1);
    send_cmd(1);
    send_pkt(16'h400, 5, 4);
    settle("R4");
    chk(err_missing == 1'b1, "R4", "err_missing set", err_missing, 1);
    chk(err_early == 1'b0, "R4", "err_early clear", err_early, 0);

    // R4 resynchronised: the next packet is clean
    expect_elems(16'h500, 1, 1'b1);
    cnt_q.push_back(1);
    send_cmd(1);
    send_pkt(16'h500, 3, 2);
    settle("R4");
    clear_flags();
    chk(err_missing == 1'b0, "R9", "err_missing cleared", err_missing, 0);

    // R10 zero count
    cnt_q.push_back(0);
    send_cmd(0);
    settle("R10");
    chk(m_valid == 1'b0, "R10", "no element", m_valid, 0);
    chk(cmd_ready == 1'b1, "R10", "back to idle", cmd_ready, 1);

    // R5 push mode with stalls
    mode_pull = 1'b0;
    stall_en  = 1'b1;
    @(negedge clk);
    #1;
    chk(cmd_ready == 1'b0, "R5", "cmd_ready in push", cmd_ready, 0);
    expect_elems(16'h600, 3, 1'b1);
    cnt_q.push_back(3);
    send_pkt(16'h600, 9, 8);
    settle("R5");
    stall_en = 1'b0;
    chk({err_early, err_missing, err_partial} == 3'b000, "R5", "no error",
        {err_early, err_missing, err_partial}, 0);

    // R6 push packet ending inside the second element
    expect_elems(16'h700, 1, 1'b0);
    cnt_q.push_back(1);
    send_pkt(16'h700, 4, 3);
    settle("R6");
    chk(err_partial == 1'b1, "R6", "err_partial set", err_partial, 1);

    // R5 push single element after a partial one
    expect_elems(16'h800, 1, 1'b1);
    cnt_q.push_back(1);
    send_pkt(16'h800, 3, 2);
    settle("R5");
    chk(err_partial == 1'b1, "R9", "err_partial sticky", err_partial, 1);

    finish_run();
  end
endmodule